// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Control Registers

This block holds the software-visible control state for a pair of bus-master disk DMA channels. Software reaches it through a small byte-addressed register window. Each channel has three registers: an 8-bit command register, an 8-bit status register and a 32-bit descriptor-table pointer. Writing the start/stop bit of a command register starts or aborts a transfer. The start or abort shows up as a one-cycle pulse per channel, and the registered descriptor pointer is presented alongside it.

The drive side reports that a transfer has finished through one completion input per drive. Drives are grouped in pairs, one pair per channel. A completion stops the channel and raises its interrupt bit. Two enable inputs gate the window. With I/O enable low, every access is dropped. With bus-master enable low, writes are dropped and reads still work. Write sizes are policed: a write of the wrong size to a register raises a one-cycle error flag and leaves that register untouched.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, each status register reads 0x60, and each command register and each pointer reads 0. Primary bytes sit at window offsets 0–7 and secondary bytes at 8–15. Within a channel the command register is at byte 0, status at byte 2 and the pointer at bytes 4–7, least significant byte first.
- R2: With `io_en` low, writes change nothing and a read leaves `reg_rdata` at its previous value. With `bm_en` low, writes change nothing, raise no pulse and raise no error, while reads still return data.
- R3: Writing command bit 0 (start/stop) from 0 to 1 does three things one cycle later. It sets status bit 0 (active), drives `dma_start` high for that channel for one cycle, and presents that channel's pointer on its `dma_ptr` slice.
- R4: Writing command bit 0 from 1 to 0 clears status bit 0 and drives `dma_abort` high for that channel for one cycle, both one cycle later.
- R5: While command bit 0 is 1, a command write keeps the stored value of command bit 3 (direction) and stores the other bits as written.
- R6: In a status write, bit 0 is read-only. Bits 1 (error) and 2 (interrupt) clear when 1 is written and are otherwise unchanged. Bits 7:3 are stored as written.
- R7: Access size is coded as `reg_size` 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = illegal. Command and status writes must be byte-sized. The pointer accepts only a 32-bit write at byte 4. Any other write to bytes 0, 2 or 4–7 while both enables are high makes `size_err` high for one cycle and changes no register. Writes to bytes 1 and 3 are ignored without error.
- R8: A pointer write stores the data with bits 1:0 forced to 0.
- R9: A pulse on completion input `done_evt[d]` acts on the channel that owns drive d: drives 0–1 belong to the primary channel and drives 2–3 to the secondary channel. It clears command bit 0 and status bit 0 and sets status bit 2.
- R10: When a completion arrives in the same cycle as a register write to the same channel, the completion wins. Command bit 0, status bit 0 and status bit 2 end as in R9, the rest of the write lands, and that channel issues no start or abort pulse.
- R11: A read returns, one cycle later, 1, 2 or 4 bytes (for `reg_size` 0, 1, 2) starting at `reg_addr`, packed little-endian from bit 0. Bytes beyond the requested size or the window, and bytes 1 and 3 of each channel, read 0. `reg_size` 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | Enables all window accesses |
| bm_en | input | 1 | Enables window writes |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 4 | Byte offset in the window |
| reg_size | input | 2 | Access size code |
| reg_wdata | input | 32 | Write data, little-endian |
| reg_rdata | output | 32 | Registered read data |
| size_err | output | 1 | One-cycle flag for an illegal write size |
| done_evt | input | 4 | Per-drive transfer completion |
| dma_start | output | 2 | Per-channel start pulse |
| dma_abort | output | 2 | Per-channel abort pulse |
| dma_ptr | output | 64 | Per-channel descriptor pointer, primary in bits 31:0 |

## Verification
The hardware completion event and a software register write can land on the same channel in the same cycle. The write may be a start, a stop, or an interrupt-clear of the status register. The bench provokes this by pulsing `done_evt` during the write strobe, for both drives of a pair and for the other channel. It judges the outcome by the absent start or abort pulse, the read-back command byte (direction landed, start/stop clear) and a status byte whose interrupt bit stays set. It also checks that a completion on one channel does not suppress a start on the other.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int SS_BIT  = 0;
  localparam int DIR_BIT = 3;
  localparam int ACT_BIT = 0;
  localparam int ERR_BIT = 1;
  localparam int IRQ_BIT = 2;
  localparam logic [7:0] STS_RST = 8'h60;
  localparam logic [2:0] OFS_CMD = 3'd0;
  localparam logic [2:0] OFS_STS = 3'd2;
  localparam logic [2:0] OFS_PTR = 3'd4;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic        sts_we,
  input  logic        ptr_we,
  input  logic [7:0]  wbyte,
  input  logic [29:0] wptr,
  input  logic        done,
  output logic [7:0]  cmd_q,
  output logic [7:0]  sts_q,
  output logic [31:0] ptr_q,
  output logic        start_p,
  output logic        abort_p
);
  logic [7:0] cmd_d, sts_d;
  logic       go, halt;

  assign go   = cmd_we & ~cmd_q[SS_BIT] &  wbyte[SS_BIT];
  assign halt = cmd_we &  cmd_q[SS_BIT] & ~wbyte[SS_BIT];

  always_comb begin
    cmd_d = cmd_q;
    sts_d = sts_q;
    if (cmd_we) begin
      cmd_d = wbyte;
      if (cmd_q[SS_BIT]) cmd_d[DIR_BIT] = cmd_q[DIR_BIT];
    end
    if (sts_we) begin
      sts_d[7:3]     = wbyte[7:3];
      sts_d[ERR_BIT] = sts_q[ERR_BIT] & ~wbyte[ERR_BIT];
      sts_d[IRQ_BIT] = sts_q[IRQ_BIT] & ~wbyte[IRQ_BIT];
    end
    if (go)   sts_d[ACT_BIT] = 1'b1;
    if (halt) sts_d[ACT_BIT] = 1'b0;
    if (done) begin
      cmd_d[SS_BIT]  = 1'b0;
      sts_d[ACT_BIT] = 1'b0;
      sts_d[IRQ_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      sts_q   <= STS_RST;
      ptr_q   <= '0;
      start_p <= 1'b0;
      abort_p <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      sts_q   <= sts_d;
      start_p <= go & ~done;
      abort_p <= halt & ~done;
      if (ptr_we) ptr_q <= {wptr, 2'b00};
    end
  end
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [AW-1:0]         addr,
  input  logic [1:0]            size,
  input  logic [NCH-1:0][7:0]   cmd_bus,
  input  logic [NCH-1:0][7:0]   sts_bus,
  input  logic [NCH-1:0][31:0]  ptr_bus,
  output logic [31:0]           rdata
);
  localparam int NB = NCH * 8;

  logic [7:0]  win [NB];
  logic [31:0] rd_next;
  int          nbytes;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar b = 0; b < 8; b++) begin : g_byte
      if (b == int'(OFS_CMD)) begin : g_cmd
        assign win[c*8+b] = cmd_bus[c];
      end else if (b == int'(OFS_STS)) begin : g_sts
        assign win[c*8+b] = sts_bus[c];
      end else if (b >= int'(OFS_PTR)) begin : g_ptr
        assign win[c*8+b] = ptr_bus[c][(b-int'(OFS_PTR))*8 +: 8];
      end else begin : g_rsv
        assign win[c*8+b] = 8'h00;
      end
    end
  end

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: nbytes = 1;
      SZ_HALF: nbytes = 2;
      SZ_WORD: nbytes = 4;
      default: nbytes = 0;
    endcase
    rd_next = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < nbytes && (int'(addr) + k) < NB)
        rd_next[k*8 +: 8] = win[int'(addr) + k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DPC = 2,
  localparam int AW = $clog2(NCH * 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_en,
  input  logic              bm_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              size_err,
  input  logic [NCH*DPC-1:0] done_evt,
  output logic [NCH-1:0]    dma_start,
  output logic [NCH-1:0]    dma_abort,
  output logic [NCH*32-1:0] dma_ptr
);
  logic [NCH-1:0][7:0]  cmd_bus;
  logic [NCH-1:0][7:0]  sts_bus;
  logic [NCH-1:0][31:0] ptr_bus;

  acc_size_e     sz;
  logic          wacc, is_byte, is_word, bad_wr;
  logic [2:0]    lo;
  logic [AW-4:0] chsel;

  assign sz      = acc_size_e'(reg_size);
  assign wacc    = reg_wr & io_en & bm_en;
  assign lo      = reg_addr[2:0];
  assign chsel   = reg_addr[AW-1:3];
  assign is_byte = (sz == SZ_BYTE);
  assign is_word = (sz == SZ_WORD);
  assign bad_wr  = wacc & ((((lo == OFS_CMD) || (lo == OFS_STS)) && !is_byte) ||
                           (lo[2] && !((lo == OFS_PTR) && is_word)));

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hit;
    assign hit = wacc & (int'(chsel) == c);

    bmdma_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .cmd_we  (hit & (lo == OFS_CMD) & is_byte),
      .sts_we  (hit & (lo == OFS_STS) & is_byte),
      .ptr_we  (hit & (lo == OFS_PTR) & is_word),
      .wbyte   (reg_wdata[7:0]),
      .wptr    (reg_wdata[31:2]),
      .done    (|done_evt[c*DPC +: DPC]),
      .cmd_q   (cmd_bus[c]),
      .sts_q   (sts_bus[c]),
      .ptr_q   (ptr_bus[c]),
      .start_p (dma_start[c]),
      .abort_p (dma_abort[c])
    );

    assign dma_ptr[c*32 +: 32] = ptr_bus[c];
  end

  always_ff @(posedge clk) begin
    if (rst) size_err <= 1'b0;
    else     size_err <= bad_wr;
  end

  bmdma_rdmux #(.NCH(NCH), .AW(AW)) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (reg_rd & io_en),
    .addr    (reg_addr),
    .size    (reg_size),
    .cmd_bus (cmd_bus),
    .sts_bus (sts_bus),
    .ptr_bus (ptr_bus),
    .rdata   (reg_rdata)
  );
endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk #(
  parameter int NCH = 2,
  parameter int DPC = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bm_en,
  input logic [NCH*DPC-1:0]    done_evt,
  input logic [NCH-1:0]        dma_start,
  input logic [NCH-1:0]        dma_abort,
  input logic                  size_err,
  input logic [NCH-1:0][7:0]   cmd_bus,
  input logic [NCH-1:0][7:0]   sts_bus,
  input logic [NCH-1:0][31:0]  ptr_bus
);
  // R2
  bm_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !bm_en |=> $stable(ptr_bus));

  // R7
  size_err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    size_err |-> $stable(ptr_bus));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R3
    start_act_chk: assert property (@(posedge clk) disable iff (rst)
      dma_start[c] |-> (sts_bus[c][0] && cmd_bus[c][0]));

    // R4
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
      dma_abort[c] |-> (!sts_bus[c][0] && !cmd_bus[c][0]));

    // R5
    dir_lock_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_bus[c][0] |=> $stable(cmd_bus[c][3]));

    // R9
    done_irq_chk: assert property (@(posedge clk) disable iff (rst)
      (|done_evt[c*DPC +: DPC]) |=> (sts_bus[c][2] && !sts_bus[c][0] && !cmd_bus[c][0]));

    // R10
    done_nopulse_chk: assert property (@(posedge clk) disable iff (rst)
      (|done_evt[c*DPC +: DPC]) |=> (!dma_start[c] && !dma_abort[c]));
  end
endmodule

bind bmdma_regfile bmdma_regfile_chk #(.NCH(NCH), .DPC(DPC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bm_en     (bm_en),
  .done_evt  (done_evt),
  .dma_start (dma_start),
  .dma_abort (dma_abort),
  .size_err  (size_err),
  .cmd_bus   (cmd_bus),
  .sts_bus   (sts_bus),
  .ptr_bus   (ptr_bus)
);

// File: tb/bmdma_regfile_tb.sv
module bmdma_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_en = 1'b0;
  logic        bm_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [1:0]  reg_size = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        size_err;
  logic [3:0]  done_evt = '0;
  logic [1:0]  dma_start, dma_abort;
  logic [63:0] dma_ptr;

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  logic [7:0]  cmd_m [2];
  logic [7:0]  sts_m [2];
  logic [31:0] ptr_m [2];
  logic        io_m, bm_m;
  logic [31:0] rd_last;

  always #10 clk = ~clk;

  bmdma_regfile dut_i (
    .clk(clk), .rst(rst), .io_en(io_en), .bm_en(bm_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .size_err(size_err),
    .done_evt(done_evt), .dma_start(dma_start), .dma_abort(dma_abort),
    .dma_ptr(dma_ptr)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int i);
    int c;
    if (i > 15) return 8'h00;
    c = i / 8;
    case (i % 8)
      0: return cmd_m[c];
      2: return sts_m[c];
      4, 5, 6, 7: return ptr_m[c][((i % 8) - 4) * 8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  // one write cycle, optional completion pulses; called at a falling edge
  task automatic apply(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d,
                       input logic [3:0] dn, input string tag);
    logic [1:0] es, ea;
    logic       ee;
    int         ch;
    int         lo;
    logic [7:0] old, nv;
    es = '0; ea = '0; ee = 1'b0;
    ch = int'(a[3]);
    lo = int'(a[2:0]);
    if (io_m && bm_m) begin
      if (((lo == 0) || (lo == 2)) && sz != 2'd0) ee = 1'b1;
      else if (lo >= 4 && !(lo == 4 && sz == 2'd2)) ee = 1'b1;
      else if (lo == 0) begin
        old = cmd_m[ch];
        nv  = d[7:0];
        if (old[0]) nv[3] = old[3];
        if (!old[0] && nv[0]) begin es[ch] = 1'b1; sts_m[ch][0] = 1'b1; end
        if (old[0] && !nv[0]) begin ea[ch] = 1'b1; sts_m[ch][0] = 1'b0; end
        cmd_m[ch] = nv;
      end else if (lo == 2) begin
        sts_m[ch][7:3] = d[7:3];
        sts_m[ch][1]   = sts_m[ch][1] & ~d[1];
        sts_m[ch][2]   = sts_m[ch][2] & ~d[2];
      end else if (lo == 4) begin
        ptr_m[ch] = {d[31:2], 2'b00};
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (|dn[c*2 +: 2]) begin
        cmd_m[c][0] = 1'b0;
        sts_m[c][0] = 1'b0;
        sts_m[c][2] = 1'b1;
        es[c] = 1'b0;
        ea[c] = 1'b0;
      end
    end
    reg_wr = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d; done_evt = dn;
    @(negedge clk);
    reg_wr = 1'b0; done_evt = '0;
    check({30'd0, dma_start}, {30'd0, es}, tag, "start pulse");
    check({30'd0, dma_abort}, {30'd0, ea}, tag, "abort pulse");
    check({31'd0, size_err}, {31'd0, ee}, tag, "size error");
    for (int c = 0; c < 2; c++)
      if (es[c]) check(dma_ptr[c*32 +: 32], ptr_m[c], tag, "pointer at start");
  endtask

  task automatic rdchk(input logic [3:0] a, input logic [1:0] sz, input string tag);
    logic [31:0] e;
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    e = '0;
    for (int k = 0; k < n; k++) e[k*8 +: 8] = mbyte(int'(a) + k);
    if (!io_m) e = rd_last;
    rd_last = e;
    reg_rd = 1'b1; reg_addr = a; reg_size = sz;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rdata, e, tag, "read data");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      cmd_m[c] = 8'h00; sts_m[c] = 8'h60; ptr_m[c] = 32'h0;
    end
    rd_last = '0;
    io_m = 1'b1; bm_m = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; io_en = 1'b1; bm_en = 1'b1;

    // R1 reset values
    check({30'd0, dma_start}, 32'd0, "R1", "start after reset");
    check({31'd0, size_err}, 32'd0, "R1", "error after reset");
    rdchk(4'd0, 2'd2, "R1");
    rdchk(4'd4, 2'd2, "R1");
    rdchk(4'd8, 2'd2, "R1");
    rdchk(4'd12, 2'd2, "R1");

    // R8 pointer low bits
    apply(4'd4, 2'd2, 32'hDEADBEEF, 4'd0, "R8");
    rdchk(4'd4, 2'd2, "R8");
    apply(4'd12, 2'd2, 32'h12345677, 4'd0, "R8");
    rdchk(4'd12, 2'd2, "R8");

    // R11 read sizes and holes
    rdchk(4'd5, 2'd0, "R11");
    rdchk(4'd6, 2'd1, "R11");
    rdchk(4'd14, 2'd2, "R11");
    rdchk(4'd1, 2'd0, "R11");
    rdchk(4'd0, 2'd3, "R11");
    rdchk(4'd10, 2'd1, "R11");

    // R3 start carries pointer
    apply(4'd0, 2'd0, 32'h0, 4'd0, "R3");
    apply(4'd0, 2'd0, 32'h1, 4'd0, "R3");
    apply(4'd8, 2'd0, 32'h1, 4'd0, "R3");
    rdchk(4'd0, 2'd2, "R3");

    // R4 / R5 command sweep on both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = 0; v < 256; v++) begin
        apply(4'(ch*8), 2'd0, 32'(v), 4'd0, "R4");
        rdchk(4'(ch*8), 2'd2, "R5");
      end
    end

    // R9 completion routing per drive
    for (int d = 0; d < 4; d++) begin
      apply(4'((d/2)*8), 2'd0, 32'h0, 4'd0, "R9");
      apply(4'((d/2)*8), 2'd0, 32'h9, 4'd0, "R9");
      apply(4'd1, 2'd0, 32'h0, 4'(1 << d), "R9");
      rdchk(4'd0, 2'd2, "R9");
      rdchk(4'd8, 2'd2, "R9");
    end

    // R6 status sweep
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = 0; v < 256; v++) begin
        apply(4'(ch*8), 2'd0, 32'h1, 4'd0, "R6");
        apply(4'd1, 2'd0, 32'h0, 4'(3 << (ch*2)), "R6");
        apply(4'(ch*8+2), 2'd0, 32'(v), 4'd0, "R6");
        rdchk(4'(ch*8), 2'd2, "R6");
        apply(4'(ch*8), 2'd0, 32'h1, 4'd0, "R6");
        apply(4'(ch*8+2), 2'd0, 32'(~v & 8'hFE), 4'd0, "R6");
        rdchk(4'(ch*8), 2'd2, "R6");
        apply(4'(ch*8), 2'd0, 32'h0, 4'd0, "R6");
      end
    end

    // R7 every offset and size
    for (int ch = 0; ch < 2; ch++) begin
      for (int lo = 0; lo < 8; lo++) begin
        for (int sz = 0; sz < 4; sz++) begin
          apply(4'(ch*8+lo), 2'(sz), 32'hA5C3_F00D ^ 32'(lo*17 + sz), 4'd0, "R7");
          rdchk(4'(ch*8), 2'd2, "R7");
          rdchk(4'(ch*8+4), 2'd2, "R7");
        end
      end
    end

    // R2 enables
    apply(4'd0, 2'd0, 32'h0, 4'd0, "R2");
    bm_en = 1'b0; bm_m = 1'b0;
    apply(4'd0, 2'd0, 32'h1, 4'd0, "R2");
    apply(4'd4, 2'd2, 32'h55AA55AA, 4'd0, "R2");
    apply(4'd4, 2'd1, 32'h0, 4'd0, "R2");
    rdchk(4'd0, 2'd2, "R2");
    rdchk(4'd4, 2'd2, "R2");
    bm_en = 1'b1; bm_m = 1'b1;
    rdchk(4'd12, 2'd2, "R2");
    io_en = 1'b0; io_m = 1'b0;
    apply(4'd8, 2'd0, 32'h0, 4'd0, "R2");
    apply(4'd8, 2'd0, 32'h1, 4'd0, "R2");
    rdchk(4'd8, 2'd2, "R2");
    io_en = 1'b1; io_m = 1'b1;
    rdchk(4'd8, 2'd2, "R2");

    // R10 completion colliding with writes
    apply(4'd0, 2'd0, 32'h0, 4'd0, "R10");
    apply(4'd0, 2'd0, 32'h9, 4'd1, "R10");
    rdchk(4'd0, 2'd2, "R10");
    apply(4'd2, 2'd0, 32'h4, 4'd2, "R10");
    rdchk(4'd0, 2'd2, "R10");
    apply(4'd0, 2'd0, 32'h1, 4'd0, "R10");
    apply(4'd0, 2'd0, 32'h0, 4'd2, "R10");
    rdchk(4'd0, 2'd2, "R10");
    apply(4'd8, 2'd0, 32'h0, 4'd0, "R10");
    apply(4'd8, 2'd0, 32'h1, 4'd1, "R10");
    rdchk(4'd8, 2'd2, "R10");
    apply(4'd8, 2'd0, 32'h0, 4'd8, "R10");
    rdchk(4'd8, 2'd2, "R10");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule